// File: doc/BRIEF.md
# Channel-Select Address Dehasher

This unit takes a system physical address whose channel-select bits were scrambled by the memory fabric's address hashing and restores the plain address. Each of five candidate select bits (8, 9, 12, 13 and 14) may be flipped by the parity of a few high address bits. Each of those high bits is gated by one of four hash enables, one per region size: 64 KiB, 2 MiB, 1 GiB and 1 TiB. A select bit is corrected only when the interleave configuration actually uses it.

The set of bits in use is not tied to a mode. It comes from a mask. The value (channel count − 1) is placed at bit 8, and a run of zero bits is then opened inside it. The position and size of that gap depend on the interleave granularity. Channel counts are powers of two from 1 to 16.

Requests enter on a valid/ready stream together with their configuration, and results leave on a second valid/ready stream after one register stage. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken.

Top module: `addr_dehash_unit`

## Requirements
- R1: A channel count of 1 gives an empty correction mask, so the output address equals the input address for any enables.
- R2: With `in_fine_gran`=1, two zero bits open at mask bit 10. Counts 2, 4, 8 and 16 then correct select bits {8}, {8,9}, {8,9,12} and {8,9,12,13}, and bit 14 is never corrected.
- R3: With `in_fine_gran`=0, three zero bits open at mask bit 9. Counts 2, 4, 8 and 16 then correct {8}, {8,12}, {8,12,13} and {8,12,13,14}, and bit 9 is never corrected.
- R4: For select index k=0..4 (bits 8, 9, 12, 13, 14), the term bits are 16+k, 21+k, 30+k and 40+k. They are gated by `in_hash_en` bits 0 (64 KiB), 1 (2 MiB), 2 (1 GiB) and 3 (1 TiB).
- R5: An enabled select bit is inverted exactly when the XOR of its enabled term bits is 1. With `in_hash_en`=0, the address passes unchanged.
- R6: Address bits other than 8, 9, 12, 13 and 14 are never altered.
- R7: A request accepted at a clock edge appears on `out_addr` with `out_valid` high right after that edge.
- R8: While `out_valid`=1 and `out_ready`=0, `out_addr` and `out_valid` hold and `in_ready` is 0. Otherwise `in_ready` is 1.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | ADDR_W (48) | Hashed address |
| in_chan_cnt | input | CHAN_W (5) | Total interleaved channels: 1, 2, 4, 8 or 16 |
| in_fine_gran | input | 1 | 1: fine granularity gap; 0: coarse gap |
| in_hash_en | input | 4 | Hash enables: bit0 64 KiB, bit1 2 MiB, bit2 1 GiB, bit3 1 TiB |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | ADDR_W (48) | Dehashed address |

## Verification
Every result is due exactly one clock edge after its request is accepted, and it stays on the outputs until an edge where `out_ready` is high. The bench drives inputs at the falling edge. It then records the acceptance and drain decisions that the next rising edge will make into a queue of expected results, and at the following falling edge it compares `out_valid`, `out_addr` and `in_ready` against the head of that queue. Each comparison is therefore made after the single register stage has updated and before any new input is applied.

// File: rtl/addr_dehash_pkg.sv
package addr_dehash_pkg;

  localparam int NUM_SEL   = 5;
  localparam int NUM_EN    = 4;
  localparam int MASK_BASE = 8;

  // gap inserted into the shifted channel mask
  localparam int FINE_GAP_AT   = 10;
  localparam int FINE_GAP_W    = 2;
  localparam int COARSE_GAP_AT = 9;
  localparam int COARSE_GAP_W  = 3;

  // position of select bit k
  function automatic int sel_pos(input int k);
    case (k)
      0:       return 8;
      1:       return 9;
      2:       return 12;
      3:       return 13;
      default: return 14;
    endcase
  endfunction

  // position of the term feeding select k under enable e
  function automatic int term_pos(input int k, input int e);
    case (e)
      0:       return 16 + k;
      1:       return 21 + k;
      2:       return 30 + k;
      default: return 40 + k;
    endcase
  endfunction

  // index into (count-1) that lands on mask bit p after a gap, or -1
  function automatic int mask_src(input int p, input int gap_at, input int gap_w);
    if (p < gap_at)               return p - MASK_BASE;
    else if (p < gap_at + gap_w)  return -1;
    else                          return p - gap_w - MASK_BASE;
  endfunction

  function automatic logic [63:0] all_sel_mask();
    logic [63:0] m;
    m = '0;
    for (int k = 0; k < NUM_SEL; k++) m[sel_pos(k)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dh_mask_gen.sv
module dh_mask_gen
  import addr_dehash_pkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic [CHAN_W-1:0]  chan_cnt,
  input  logic               fine_gran,
  output logic [NUM_SEL-1:0] sel_mask
);

  logic [CHAN_W-1:0]  cnt_m1;
  logic [NUM_SEL-1:0] fine_m;
  logic [NUM_SEL-1:0] coarse_m;

  assign cnt_m1 = chan_cnt - CHAN_W'(1);

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_bit
    localparam int SRC_F = mask_src(sel_pos(k), FINE_GAP_AT, FINE_GAP_W);
    localparam int SRC_C = mask_src(sel_pos(k), COARSE_GAP_AT, COARSE_GAP_W);
    if (SRC_F >= 0 && SRC_F < CHAN_W) begin : g_f
      assign fine_m[k] = cnt_m1[SRC_F];
    end else begin : g_fz
      assign fine_m[k] = 1'b0;
    end
    if (SRC_C >= 0 && SRC_C < CHAN_W) begin : g_c
      assign coarse_m[k] = cnt_m1[SRC_C];
    end else begin : g_cz
      assign coarse_m[k] = 1'b0;
    end
  end

  assign sel_mask = fine_gran ? fine_m : coarse_m;

endmodule

// File: rtl/dh_fix_stage.sv
module dh_fix_stage
  import addr_dehash_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SEL_K  = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_EN-1:0] hash_en,
  input  logic              apply,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int SEL = sel_pos(SEL_K);

  logic [NUM_EN-1:0] terms;
  logic              parity;

  for (genvar e = 0; e < NUM_EN; e++) begin : g_term
    assign terms[e] = addr_i[term_pos(SEL_K, e)];
  end

  assign parity = ^(terms & hash_en);

  always_comb begin
    addr_o      = addr_i;
    addr_o[SEL] = addr_i[SEL] ^ (apply & parity);
  end

endmodule

// File: rtl/dh_out_reg.sv
module dh_out_reg #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end

endmodule

// File: rtl/addr_dehash_unit.sv
module addr_dehash_unit
  import addr_dehash_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CHAN_W-1:0] in_chan_cnt,
  input  logic              in_fine_gran,
  input  logic [NUM_EN-1:0] in_hash_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);

  logic [NUM_SEL-1:0] sel_mask;
  logic [ADDR_W-1:0]  chain [NUM_SEL+1];

  dh_mask_gen #(.CHAN_W(CHAN_W)) u_mask (
    .chan_cnt  (in_chan_cnt),
    .fine_gran (in_fine_gran),
    .sel_mask  (sel_mask)
  );

  assign chain[0] = in_addr;

  // ascending select order on the running address
  for (genvar k = 0; k < NUM_SEL; k++) begin : g_fix
    dh_fix_stage #(.ADDR_W(ADDR_W), .SEL_K(k)) u_stage (
      .addr_i  (chain[k]),
      .hash_en (in_hash_en),
      .apply   (sel_mask[k]),
      .addr_o  (chain[k+1])
    );
  end

  dh_out_reg #(.W(ADDR_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (chain[NUM_SEL]),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_addr)
  );

endmodule

// File: rtl/addr_dehash_chk.sv
module addr_dehash_chk
  import addr_dehash_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CHAN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [CHAN_W-1:0] in_chan_cnt,
  input logic              in_fine_gran,
  input logic [NUM_EN-1:0] in_hash_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr
);

  localparam logic [63:0]       SEL_ALL = all_sel_mask();
  localparam logic [ADDR_W-1:0] KEEP    = ~SEL_ALL[ADDR_W-1:0];
  localparam int                BIT_A   = sel_pos(1);
  localparam int                BIT_B   = sel_pos(4);

  logic acc;
  assign acc = in_valid && in_ready;

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8

  AST_ONE_CHAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_chan_cnt == CHAN_W'(1) |=> out_addr == $past(in_addr)); // R1

  AST_NO_EN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_hash_en == '0 |=> out_addr == $past(in_addr)); // R5

  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((out_addr ^ $past(in_addr)) & KEEP) == '0); // R6

  AST_FINE_SKIPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_fine_gran && in_chan_cnt <= CHAN_W'(16)
    |=> out_addr[BIT_B] == $past(in_addr[BIT_B])); // R2

  AST_COARSE_SKIPS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_fine_gran |=> out_addr[BIT_A] == $past(in_addr[BIT_A])); // R3

endmodule

bind addr_dehash_unit addr_dehash_chk #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_addr      (in_addr),
  .in_chan_cnt  (in_chan_cnt),
  .in_fine_gran (in_fine_gran),
  .in_hash_en   (in_hash_en),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_addr     (out_addr)
);

// File: tb/test_addr_dehash_unit.sv
module test_addr_dehash_unit;

  localparam int AW = 48;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [CW-1:0] in_chan_cnt = CW'(1);
  logic          in_fine_gran = 1'b0;
  logic [3:0]    in_hash_en = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int errors = 0;
  string cur_req = "R9";

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  always #2 clk = ~clk;

  addr_dehash_unit i_addr_dehash_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_chan_cnt(in_chan_cnt), .in_fine_gran(in_fine_gran),
    .in_hash_en(in_hash_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr)
  );

  function automatic logic [AW-1:0] ref_fix(logic [AW-1:0] a, int cnt, bit fine,
                                            logic [3:0] en);
    int fl[4] = '{8, 9, 12, 13};
    int cl[4] = '{8, 12, 13, 14};
    int base[4] = '{16, 21, 30, 40};
    logic [AW-1:0] r = a;
    int n = 0;
    int c = cnt;
    while (c > 1) begin n++; c = c / 2; end
    for (int i = 0; i < n; i++) begin
      int pos = fine ? fl[i] : cl[i];
      int k = (pos == 8) ? 0 : (pos == 9) ? 1 : pos - 10;
      logic x = 1'b0;
      for (int e = 0; e < 4; e++) if (en[e]) x ^= r[base[e] + k];
      if (x) r[pos] = ~r[pos];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(bit v, logic [AW-1:0] a, int cnt, bit fine, logic [3:0] en, bit ordy);
    bit mready;
    @(negedge clk);
    // outputs reflect the edge just passed
    chk(out_valid == (exp_q.size() != 0), "R7", AW'(out_valid), AW'(exp_q.size() != 0));
    if (exp_q.size() != 0) chk(out_addr == exp_q[0], tag_q[0], out_addr, exp_q[0]);
    in_valid = v; in_addr = a; in_chan_cnt = CW'(cnt); in_fine_gran = fine;
    in_hash_en = en; out_ready = ordy;
    #1;
    mready = (exp_q.size() == 0) || ordy;
    chk(in_ready == mready, "R8", AW'(in_ready), AW'(mready));
    if (exp_q.size() != 0 && ordy) begin
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
    if (v && mready) begin
      exp_q.push_back(ref_fix(a, cnt, fine, en)); tag_q.push_back(cur_req);
    end
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    return {$urandom(), $urandom()} & {AW{1'b1}};
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", AW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", AW'(out_valid), '0);
    chk(in_ready == 1'b1, "R9", AW'(in_ready), AW'(1));

    cur_req = "R1";
    for (int i = 0; i < 6; i++) cycle(1, rnd_addr(), 1, i[0], 4'hF, 1);

    cur_req = "R4";
    for (int k = 0; k < 5; k++)
      for (int e = 0; e < 4; e++) begin
        int tp = (e == 0) ? 16 + k : (e == 1) ? 21 + k : (e == 2) ? 30 + k : 40 + k;
        cycle(1, AW'(1) << tp, 16, 1, 4'(1 << e), 1);
        cycle(1, AW'(1) << tp, 16, 0, 4'(1 << e), 1);
        cycle(1, AW'(1) << tp, 16, 0, 4'hF & ~4'(1 << e), 1);
      end

    cur_req = "R2";
    for (int c = 2; c <= 16; c = c * 2) begin
      cycle(1, {AW{1'b1}}, c, 1, 4'hF, 1);
      cycle(1, AW'(1) << 44, c, 1, 4'h8, 1);
      cycle(1, rnd_addr(), c, 1, 4'(c - 1), 1);
    end

    cur_req = "R3";
    for (int c = 2; c <= 16; c = c * 2) begin
      cycle(1, {AW{1'b1}}, c, 0, 4'hF, 1);
      cycle(1, AW'(1) << 41, c, 0, 4'h8, 1);
      cycle(1, rnd_addr(), c, 0, 4'(c - 1), 1);
    end

    cur_req = "R5";
    for (int i = 0; i < 8; i++) cycle(1, rnd_addr(), 16, i[0], 4'h0, 1);
    cycle(1, (AW'(1) << 16) | (AW'(1) << 21), 16, 0, 4'h3, 1);

    cur_req = "R6";
    for (int i = 0; i < 200; i++)
      cycle(1, rnd_addr(), 1 << ($urandom() % 5), $urandom() % 2, 4'($urandom()), 1);

    cur_req = "R8";
    for (int i = 0; i < 600; i++)
      cycle($urandom() % 3 != 0, rnd_addr(), 1 << ($urandom() % 5), $urandom() % 2,
            4'($urandom()), $urandom() % 2);
    for (int i = 0; i < 6; i++) cycle(1, rnd_addr(), 8, 1, 4'hF, 0);

    cur_req = "R7";
    for (int i = 0; i < 4; i++) cycle(0, '0, 1, 0, 4'h0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule